// File: doc/BRIEF.md
# Circular Queue Pointer Tracker

This block keeps the producer and consumer positions of a ring of fixed-size entries held in memory. The ring holds a power-of-two number of entries, and software sets that power at run time. Each position is an entry index plus one extra wrap bit that sits just above the index. The extra bit tells a full ring from an empty one without a separate counter. The block reports full and empty, and it moves either position forward on a one-cycle request. It also gives the byte address of the entry at each position, computed from a base address and a fixed entry size.

The consumer word also carries a 7-bit error code. This code is sticky: moving the consumer forward never changes it. It can be written on its own, for example when the agent that drains the ring finds a malformed entry. Register writes from the host bus load the positions, the base and the error code. The memory accesses to the entries belong to the logic around this block.

Top module: `cq_ptr_tracker`

## Requirements
- R1: After reset both positions, the error code and both drop flags are zero, `empty_o` is 1 and `full_o` is 0.
- R2: `empty_o` is 1 exactly when the low L+1 bits of the two positions are equal. L is the effective log2 size.
- R3: `full_o` is 1 exactly when the low L bits (the index) of the two positions are equal and bit L (the wrap bit) differs.
- R4: An accepted advance adds one to the position modulo 2^(L+1), so the wrap bit at bit L toggles each time the index rolls over from 2^L-1 to 0.
- R5: A producer advance while full, or a consumer advance while empty, leaves that position unchanged. It raises `prod_drop_o` or `cons_drop_o` for exactly one cycle, starting one edge after the request.
- R6: `cons_o` shows the error code in bits 30:24 and the position in its low bits, with bit 31 always zero. A consumer advance never changes bits 30:24.
- R7: `err_we_i` loads `err_code_i` into bits 30:24 at the next edge without touching either position. When it falls in the same cycle as a consumer write or a consumer advance, the error field takes `err_code_i` and the position still follows its own request.
- R8: Each entry address is (base AND a mask that keeps bits 51:6) plus ENTRY_BYTES times the index of that position. `prod_addr_o` uses the producer index and `cons_addr_o` the consumer index.
- R9: A `log2size_i` above MAX_LOG2 is treated as MAX_LOG2.
- R10: Position and base writes take effect at the next clock edge. A written position is masked to L+1 bits. A write takes priority over an advance requested on the same side in the same cycle.
- R11: Producer and consumer advances requested in the same cycle are each judged against the state before that edge, and each accepted one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| log2size_i | input | LOG2_IN_W | Requested log2 of the ring size |
| base_we_i | input | 1 | Load the base address |
| base_i | input | 64 | Base address value |
| prod_we_i | input | 1 | Load the producer position |
| prod_wdata_i | input | 32 | Producer position value |
| cons_we_i | input | 1 | Load the consumer word (position and error code) |
| cons_wdata_i | input | 32 | Consumer word value |
| err_we_i | input | 1 | Load the error code alone |
| err_code_i | input | 7 | Error code value |
| prod_inc_i | input | 1 | Advance the producer by one |
| cons_inc_i | input | 1 | Advance the consumer by one |
| prod_o | output | 32 | Producer position (wrap bit and index) |
| cons_o | output | 32 | Consumer word: error code in 30:24, position in the low bits |
| full_o | output | 1 | Ring full |
| empty_o | output | 1 | Ring empty |
| prod_addr_o | output | 64 | Byte address of the producer entry |
| cons_addr_o | output | 64 | Byte address of the consumer entry |
| prod_drop_o | output | 1 | A producer advance was refused last cycle |
| cons_drop_o | output | 1 | A consumer advance was refused last cycle |

## Verification
Two pairs of functions can meet in one cycle: the two advances, and a consumer advance with an error-code write. The bench first fills the ring. It then requests both advances in the same cycle and checks that the consumer moves while the producer is refused with a drop pulse. A second pair of joint advances, from a non-full state, must move both positions. The bench also pairs an error write with a consumer advance, and then with a consumer write. It compares the whole consumer word against the value expected from each request on its own.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned ERR_LSB   = 24;
  localparam int unsigned ERR_W     = 7;
  localparam int unsigned ADDR_W    = 64;
  localparam logic [ADDR_W-1:0] BASE_MASK = 64'h000F_FFFF_FFFF_FFC0;

  typedef struct packed {
    logic [REG_W-1:0] idx_mask;
    logic [REG_W-1:0] wrap_mask;
    logic [REG_W-1:0] ptr_mask;
  } q_masks_t;
endpackage

// File: rtl/cq_size_decode.sv
module cq_size_decode #(
  parameter int unsigned MAX_LOG2  = 19,
  parameter int unsigned LOG2_IN_W = 5
) (
  input  logic [LOG2_IN_W-1:0] log2size_i,
  output cq_pkg::q_masks_t     masks_o
);
  import cq_pkg::*;

  localparam logic [LOG2_IN_W-1:0] MAX_L = LOG2_IN_W'(MAX_LOG2);

  logic [LOG2_IN_W-1:0] eff;
  logic [REG_W-1:0]     wrap;

  always_comb begin
    eff              = (log2size_i > MAX_L) ? MAX_L : log2size_i;
    wrap             = REG_W'(1) << eff;
    masks_o.wrap_mask = wrap;
    masks_o.idx_mask  = wrap - REG_W'(1);
    masks_o.ptr_mask  = (wrap << 1) - REG_W'(1);
  end
endmodule

// File: rtl/cq_ptr_reg.sv
module cq_ptr_reg #(
  parameter int unsigned PTR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cq_pkg::q_masks_t  masks_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              inc_i,
  input  logic              block_i,
  output logic [31:0]       ptr_o,
  output logic              drop_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             drop_q;

  assign ptr_o  = 32'(ptr_q) & masks_i.ptr_mask;
  assign drop_o = drop_q;

  always_comb begin
    ptr_d = ptr_q;
    if (we_i)                ptr_d = PTR_W'(wdata_i & masks_i.ptr_mask);
    else if (inc_i && !block_i) ptr_d = PTR_W'((ptr_o + 32'd1) & masks_i.ptr_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      drop_q <= inc_i && block_i && !we_i;
    end
  end
endmodule

// File: rtl/cq_addr_gen.sv
module cq_addr_gen #(
  parameter int unsigned ENTRY_BYTES = 16
) (
  input  logic [63:0] base_i,
  input  logic [31:0] idx_i,
  output logic [63:0] addr_o
);
  import cq_pkg::*;

  localparam bit POW2 = (ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0;
  localparam int unsigned SH = $clog2(ENTRY_BYTES);

  logic [63:0] off;

  generate
    if (POW2) begin : g_shift
      assign off = 64'(idx_i) << SH;
    end else begin : g_mul
      assign off = 64'(idx_i) * 64'(ENTRY_BYTES);
    end
  endgenerate

  assign addr_o = (base_i & BASE_MASK) + off;
endmodule

// File: rtl/cq_ptr_tracker.sv
module cq_ptr_tracker #(
  parameter int unsigned MAX_LOG2    = 19,
  parameter int unsigned LOG2_IN_W   = 5,
  parameter int unsigned ENTRY_BYTES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LOG2_IN_W-1:0] log2size_i,
  input  logic                 base_we_i,
  input  logic [63:0]          base_i,
  input  logic                 prod_we_i,
  input  logic [31:0]          prod_wdata_i,
  input  logic                 cons_we_i,
  input  logic [31:0]          cons_wdata_i,
  input  logic                 err_we_i,
  input  logic [6:0]           err_code_i,
  input  logic                 prod_inc_i,
  input  logic                 cons_inc_i,
  output logic [31:0]          prod_o,
  output logic [31:0]          cons_o,
  output logic                 full_o,
  output logic                 empty_o,
  output logic [63:0]          prod_addr_o,
  output logic [63:0]          cons_addr_o,
  output logic                 prod_drop_o,
  output logic                 cons_drop_o
);
  import cq_pkg::*;

  localparam int unsigned PTR_W = MAX_LOG2 + 1;

  q_masks_t         masks;
  logic [63:0]      base_q;
  logic [ERR_W-1:0] err_q;
  logic [31:0]      cons_ptr;
  logic [31:0]      diff;

  cq_size_decode #(.MAX_LOG2(MAX_LOG2), .LOG2_IN_W(LOG2_IN_W)) u_size (
    .log2size_i (log2size_i),
    .masks_o    (masks)
  );

  // occupancy from registered positions
  assign diff    = (prod_o ^ cons_ptr) & masks.ptr_mask;
  assign empty_o = (diff == 32'd0);
  assign full_o  = (diff == masks.wrap_mask);

  cq_ptr_reg #(.PTR_W(PTR_W)) u_prod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .masks_i (masks),
    .we_i    (prod_we_i),
    .wdata_i (prod_wdata_i),
    .inc_i   (prod_inc_i),
    .block_i (full_o),
    .ptr_o   (prod_o),
    .drop_o  (prod_drop_o)
  );

  cq_ptr_reg #(.PTR_W(PTR_W)) u_cons (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .masks_i (masks),
    .we_i    (cons_we_i),
    .wdata_i (cons_wdata_i),
    .inc_i   (cons_inc_i),
    .block_i (empty_o),
    .ptr_o   (cons_ptr),
    .drop_o  (cons_drop_o)
  );

  // error code: dedicated write wins over the consumer word write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      base_q <= '0;
    end else begin
      if (err_we_i)       err_q <= err_code_i;
      else if (cons_we_i) err_q <= cons_wdata_i[ERR_LSB +: ERR_W];
      if (base_we_i)      base_q <= base_i;
    end
  end

  assign cons_o = {1'b0, err_q, cons_ptr[ERR_LSB-1:0]};

  cq_addr_gen #(.ENTRY_BYTES(ENTRY_BYTES)) u_paddr (
    .base_i (base_q),
    .idx_i  (prod_o & masks.idx_mask),
    .addr_o (prod_addr_o)
  );

  cq_addr_gen #(.ENTRY_BYTES(ENTRY_BYTES)) u_caddr (
    .base_i (base_q),
    .idx_i  (cons_ptr & masks.idx_mask),
    .addr_o (cons_addr_o)
  );
endmodule

// File: rtl/cq_ptr_tracker_chk.sv
module cq_ptr_tracker_chk #(
  parameter int unsigned LOG2_IN_W = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [LOG2_IN_W-1:0] log2size_i,
  input logic                 prod_we_i,
  input logic                 cons_we_i,
  input logic                 err_we_i,
  input logic [6:0]           err_code_i,
  input logic                 prod_inc_i,
  input logic                 cons_inc_i,
  input logic [31:0]          prod_o,
  input logic [31:0]          cons_o,
  input logic                 full_o,
  input logic                 empty_o,
  input logic                 prod_drop_o,
  input logic                 cons_drop_o
);
  p_prod_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_drop_o |-> $past(full_o && prod_inc_i && !prod_we_i));

  p_cons_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cons_drop_o |-> $past(empty_o && cons_inc_i && !cons_we_i));

  p_prod_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && prod_inc_i && !prod_we_i) |=>
      (!$stable(log2size_i) || prod_o == $past(prod_o)));

  p_cons_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && cons_inc_i && !cons_we_i) |=>
      (!$stable(log2size_i) || cons_o == $past(cons_o)));

  p_err_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_we_i && !cons_we_i) |=> $stable(cons_o[30:24]));

  p_err_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_we_i |=> (cons_o[30:24] == $past(err_code_i)));

  p_top_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cons_o[31]);
endmodule

bind cq_ptr_tracker cq_ptr_tracker_chk #(.LOG2_IN_W(LOG2_IN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .log2size_i  (log2size_i),
  .prod_we_i   (prod_we_i),
  .cons_we_i   (cons_we_i),
  .err_we_i    (err_we_i),
  .err_code_i  (err_code_i),
  .prod_inc_i  (prod_inc_i),
  .cons_inc_i  (cons_inc_i),
  .prod_o      (prod_o),
  .cons_o      (cons_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .prod_drop_o (prod_drop_o),
  .cons_drop_o (cons_drop_o)
);

// File: tb/cq_ptr_tracker_bench.sv
`timescale 1ns/1ps
module cq_ptr_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  log2size = 5'd2;
  logic        base_we = 1'b0;
  logic [63:0] base = '0;
  logic        prod_we = 1'b0;
  logic [31:0] prod_wdata = '0;
  logic        cons_we = 1'b0;
  logic [31:0] cons_wdata = '0;
  logic        err_we = 1'b0;
  logic [6:0]  err_code = '0;
  logic        prod_inc = 1'b0;
  logic        cons_inc = 1'b0;
  logic [31:0] prod, cons;
  logic        full, empty, prod_drop, cons_drop;
  logic [63:0] prod_addr, cons_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  cq_ptr_tracker u_cq_ptr_tracker (
    .clk_i(clk), .rst_ni(rst_n), .log2size_i(log2size),
    .base_we_i(base_we), .base_i(base),
    .prod_we_i(prod_we), .prod_wdata_i(prod_wdata),
    .cons_we_i(cons_we), .cons_wdata_i(cons_wdata),
    .err_we_i(err_we), .err_code_i(err_code),
    .prod_inc_i(prod_inc), .cons_inc_i(cons_inc),
    .prod_o(prod), .cons_o(cons), .full_o(full), .empty_o(empty),
    .prod_addr_o(prod_addr), .cons_addr_o(cons_addr),
    .prod_drop_o(prod_drop), .cons_drop_o(cons_drop)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // advance one edge, sample at the following falling edge, clear strobes
  task automatic tick();
    @(negedge clk);
    base_we = 0; prod_we = 0; cons_we = 0; err_we = 0;
    prod_inc = 0; cons_inc = 0;
  endtask

  task automatic t_reset();
    chk("R1", "prod", prod, 0);
    chk("R1", "cons", cons, 0);
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "drops", {prod_drop, cons_drop}, 0);
  endtask

  task automatic t_fill_wrap();
    log2size = 5'd2;
    for (int i = 0; i < 3; i++) begin prod_inc = 1; tick(); end
    chk("R4", "prod after 3", prod, 3);
    chk("R2", "empty partial", empty, 0);
    chk("R3", "full partial", full, 0);
    prod_inc = 1; tick();
    chk("R4", "prod wrap bit", prod, 4);
    chk("R3", "full", full, 1);
    for (int i = 0; i < 4; i++) begin cons_inc = 1; tick(); end
    chk("R4", "cons", cons, 4);
    chk("R2", "empty after drain", empty, 1);
    for (int i = 0; i < 4; i++) begin prod_inc = 1; tick(); end
    chk("R4", "prod wrap toggles back", prod, 0);
    chk("R3", "full wrap differs", full, 1);
    for (int i = 0; i < 4; i++) begin cons_inc = 1; tick(); end
    chk("R2", "empty again", empty, 1);
  endtask

  task automatic t_block();
    cons_inc = 1; tick();
    chk("R5", "cons held on empty", cons, 0);
    chk("R5", "cons drop pulse", cons_drop, 1);
    tick();
    chk("R5", "cons drop clears", cons_drop, 0);
    for (int i = 0; i < 4; i++) begin prod_inc = 1; tick(); end
    prod_inc = 1; tick();
    chk("R5", "prod held on full", prod, 4);
    chk("R5", "prod drop pulse", prod_drop, 1);
    tick();
    chk("R5", "prod drop clears", prod_drop, 0);
  endtask

  task automatic t_simul();
    prod_inc = 1; cons_inc = 1; tick();
    chk("R11", "prod refused when full", prod, 4);
    chk("R11", "cons moves", cons, 1);
    chk("R11", "prod drop", prod_drop, 1);
    prod_inc = 1; cons_inc = 1; tick();
    chk("R11", "prod moves", prod, 5);
    chk("R11", "cons moves again", cons, 2);
    chk("R11", "no drop", {prod_drop, cons_drop}, 0);
    chk("R3", "not full", full, 0);
  endtask

  task automatic t_err();
    err_we = 1; err_code = 7'h5A; tick();
    chk("R7", "err load, ptr kept", cons, 32'h5A00_0002);
    chk("R7", "prod untouched", prod, 5);
    cons_inc = 1; tick();
    chk("R6", "inc keeps err", cons, 32'h5A00_0003);
    err_we = 1; err_code = 7'h11; cons_inc = 1; tick();
    chk("R7", "err with inc", cons, 32'h1100_0004);
    cons_we = 1; cons_wdata = 32'h7F00_0001; err_we = 1; err_code = 7'h22; tick();
    chk("R7", "err beats cons word", cons, 32'h2200_0001);
  endtask

  task automatic t_write();
    prod_we = 1; prod_wdata = 32'hFFFF_FFF6; prod_inc = 1; tick();
    chk("R10", "write beats inc, masked", prod, 6);
  endtask

  task automatic t_addr();
    base_we = 1; base = 64'hFFF1_2345_6789_ABFF; tick();
    chk("R8", "prod addr", prod_addr, 64'h0001_2345_6789_ABE0);
    chk("R8", "cons addr", cons_addr, 64'h0001_2345_6789_ABD0);
  endtask

  task automatic t_clamp();
    log2size = 5'd31;
    prod_we = 1; prod_wdata = 32'hFFFF_FFFF; tick();
    chk("R9", "prod clamp", prod, 32'h000F_FFFF);
    chk("R9", "addr clamp", prod_addr, 64'h0001_2345_6809_ABB0);
    chk("R9", "cons word", cons, 32'h2200_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_wrap();
    t_block();
    t_simul();
    t_err();
    t_write();
    t_addr();
    t_clamp();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule